// File: doc/BRIEF.md
# Three-Phase Rotating-Frame Phase Tracker

This block follows the phase and frequency of three sampled phase voltages. On every sample strobe it rotates the three inputs into a frame that turns with its own angle estimate. The quadrature part of that projection is divided by an estimate of the input magnitude and fed to a proportional-integral loop. The sum of the integral path and the rated frequency word is the frequency estimate. That estimate plus the proportional term is added to a wrapping angle accumulator.

The outputs are the angle, the frequency word, the direct, quadrature and common-mode components captured at the last strobe, and a unit sine that follows phase a together with a copy delayed by a quarter turn. A controller in a grid-tied converter uses the angle to turn its current references, and the direct component to see the voltage magnitude. The gain that adapts the integral path slows down false frequency swings after a phase jump. A parameter set to zero turns it off.

Top module: `srf_pll3`

## Requirements
- R1: While rst_ni is low and after its release, angle_o is 0, freq_o equals the nominal increment NOM_INC = RATED_HZ·2^ANG_W/SAMPLE_HZ (512 by default), d_o, q_o and z_o are 0, sin_o is 0 and quad_o is -32767.
- R2: angle_o, freq_o, d_o, q_o and z_o change only on a clock edge where sample_i is high. Input changes without a strobe leave them unchanged.
- R3: Phase a is taken as A·sin(φ), phase b lags it by 120° and phase c leads it by 120°. With α = (2va−vb−vc)/3 and β = (vb−vc)/√3, the block forms d = α·sinθ − β·cosθ and q = α·cosθ + β·sinθ, where θ is angle_o before the strobe. A balanced input at φ = θ gives d = A and q = 0. At φ = θ + 90° it gives d = 0 and q = A.
- R4: z_o is the mean of the three phases. Three equal inputs give d = q = 0 and leave the frequency word unchanged.
- R5: The loop error is q divided by the magnitude estimate max(|α|,|β|) + 3/8·min(|α|,|β|), clamped to ±1 (Q15). The angle and frequency response to a given phase offset is therefore the same for any amplitude above the floor.
- R6: The divisor is never below AO/1000 (16 counts by default). An input smaller than that gives a proportionally smaller error.
- R7: freq_o is NOM_INC plus the integral state taken at its integer position. It does not contain the proportional term.
- R8: On each strobe, angle_o advances by the new freq_o plus KP·error, modulo 2^ANG_W (65536 is one turn). With zero error it advances by exactly freq_o, so 128 idle strobes complete one turn.
- R9: When LAMBDA is non-zero, the integral gain used on a strobe is KI/(1 + LAMBDA·|error|). When LAMBDA is 0, the full KI is used.
- R10: sin_o is the Q15 sine of the top 6 bits of angle_o (64 points per turn, full scale 32767). quad_o is the sine a quarter turn earlier. Angle 16384 gives 32767/0 and angle 32768 gives 0/32767.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | 1 | Sample strobe; all state updates on it |
| va_i | input | DATA_W | Phase a sample, signed |
| vb_i | input | DATA_W | Phase b sample, signed |
| vc_i | input | DATA_W | Phase c sample, signed |
| angle_o | output | ANG_W | Angle estimate, one turn = 2^ANG_W |
| freq_o | output | ANG_W | Frequency estimate, angle LSB per sample |
| d_o | output | DATA_W | Direct component, signed |
| q_o | output | DATA_W | Quadrature component, signed |
| z_o | output | DATA_W | Common-mode component, signed |
| sin_o | output | 16 | Unit sine following phase a, Q15 |
| quad_o | output | 16 | Unit sine delayed a quarter turn, Q15 |

## Verification
The proportional and integral paths both act on the same strobe edge. freq_o moves by the integral increment, while angle_o moves by that frequency plus the proportional kick. The bench provokes this by applying an input that leads the estimate by a quarter turn. It then checks that the angle step minus freq_o equals the proportional gain and that freq_o alone rose only by the integral share. The same edge also applies either the amplitude floor or the adaptive gain. A tiny input and a second instance with adaptation enabled each show their effect on that single step.

// File: rtl/srf_pll3_pkg.sv
package srf_pll3_pkg;
  localparam int LUT_BITS = 6;
  localparam int QTR      = 1 << (LUT_BITS - 2);
  localparam int TRIG_W   = 16;
  localparam int QS       = 15;
  localparam int HALF_LSB = 1 << (QS - 1);

  function automatic logic [TRIG_W-1:0] quarter_wave(input logic [4:0] k);
    case (k)
      5'd0:  return 16'd0;
      5'd1:  return 16'd3212;
      5'd2:  return 16'd6393;
      5'd3:  return 16'd9512;
      5'd4:  return 16'd12539;
      5'd5:  return 16'd15446;
      5'd6:  return 16'd18204;
      5'd7:  return 16'd20787;
      5'd8:  return 16'd23170;
      5'd9:  return 16'd25329;
      5'd10: return 16'd27245;
      5'd11: return 16'd28898;
      5'd12: return 16'd30273;
      5'd13: return 16'd31356;
      5'd14: return 16'd32137;
      5'd15: return 16'd32609;
      default: return 16'd32767;
    endcase
  endfunction

  // quadrant in idx[5:4], position in idx[3:0]
  function automatic logic signed [TRIG_W-1:0] sine_q15(input logic [LUT_BITS-1:0] idx);
    logic [4:0]        pos;
    logic [TRIG_W-1:0] mag;
    pos = idx[4] ? (5'd16 - {1'b0, idx[3:0]}) : {1'b0, idx[3:0]};
    mag = quarter_wave(pos);
    return idx[5] ? -$signed(mag) : $signed(mag);
  endfunction
endpackage

// File: rtl/srf_pll3_sine.sv
module srf_pll3_sine
  import srf_pll3_pkg::*;
#(
  parameter int OFFSET = 0
) (
  input  logic [LUT_BITS-1:0]      idx_i,
  output logic signed [TRIG_W-1:0] val_o
);
  logic [LUT_BITS-1:0] idx_s;
  assign idx_s = LUT_BITS'(idx_i + LUT_BITS'(OFFSET));
  assign val_o = sine_q15(idx_s);
endmodule

// File: rtl/srf_pll3_park.sv
module srf_pll3_park
  import srf_pll3_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int XW     = DATA_W + 2
) (
  input  logic signed [DATA_W-1:0] va_i,
  input  logic signed [DATA_W-1:0] vb_i,
  input  logic signed [DATA_W-1:0] vc_i,
  input  logic signed [TRIG_W-1:0] sin_i,
  input  logic signed [TRIG_W-1:0] cos_i,
  output logic signed [XW-1:0]     alpha_o,
  output logic signed [XW-1:0]     beta_o,
  output logic signed [XW-1:0]     d_o,
  output logic signed [XW-1:0]     q_o,
  output logic signed [XW-1:0]     z_o
);
  localparam int SW = DATA_W + 2;
  localparam int PW = SW + TRIG_W;
  localparam int MW = XW + TRIG_W + 1;
  localparam logic signed [TRIG_W-1:0] K_THIRD = 16'sd10923;  // 1/3 in Q15
  localparam logic signed [TRIG_W-1:0] K_RSQ3  = 16'sd18919;  // 1/sqrt(3) in Q15

  logic signed [SW-1:0] s_a, s_b, s_z;
  logic signed [MW-1:0] m_d, m_q;

  assign s_a = (SW'(va_i) <<< 1) - SW'(vb_i) - SW'(vc_i);
  assign s_b = SW'(vb_i) - SW'(vc_i);
  assign s_z = SW'(va_i) + SW'(vb_i) + SW'(vc_i);

  assign alpha_o = XW'((PW'(s_a) * PW'(K_THIRD) + PW'(HALF_LSB)) >>> QS);
  assign beta_o  = XW'((PW'(s_b) * PW'(K_RSQ3)  + PW'(HALF_LSB)) >>> QS);
  assign z_o     = XW'((PW'(s_z) * PW'(K_THIRD) + PW'(HALF_LSB)) >>> QS);

  assign m_d = MW'(alpha_o) * MW'(sin_i) - MW'(beta_o) * MW'(cos_i) + MW'(HALF_LSB);
  assign m_q = MW'(alpha_o) * MW'(cos_i) + MW'(beta_o) * MW'(sin_i) + MW'(HALF_LSB);
  assign d_o = XW'(m_d >>> QS);
  assign q_o = XW'(m_q >>> QS);
endmodule

// File: rtl/srf_pll3_loop.sv
module srf_pll3_loop
  import srf_pll3_pkg::*;
#(
  parameter int ANG_W   = 16,
  parameter int XW      = 18,
  parameter int FRAC    = 8,
  parameter int KP      = 179,
  parameter int KI      = 402,
  parameter int LAMBDA  = 10,
  parameter int NOM_INC = 512,
  parameter int FLOOR   = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_i,
  input  logic signed [XW-1:0] alpha_i,
  input  logic signed [XW-1:0] beta_i,
  input  logic signed [XW-1:0] q_i,
  output logic [ANG_W-1:0]     angle_o,
  output logic [ANG_W-1:0]     freq_o
);
  localparam int IW = ANG_W + FRAC + 4;
  localparam int NW = XW + QS + 1;
  localparam int EMAX = (1 << QS) - 1;
  localparam logic [XW:0] FLOOR_V = (XW+1)'(FLOOR);
  localparam logic signed [31:0] KP_S = KP;

  logic [XW-1:0]             abs_a, abs_b, mx, mn;
  logic [XW+1:0]             mn_w;
  logic [XW:0]               mag, mag_f;
  logic signed [NW-1:0]      num, quot;
  logic signed [TRIG_W-1:0]  err;
  logic [31:0]               ki_eff;
  logic signed [47:0]        prop_w, inc_w;
  logic signed [IW-1:0]      acc_q, acc_n;
  logic [ANG_W-1:0]          freq_n;

  assign abs_a = XW'(alpha_i[XW-1] ? -alpha_i : alpha_i);
  assign abs_b = XW'(beta_i[XW-1]  ? -beta_i  : beta_i);
  assign mx    = (abs_a > abs_b) ? abs_a : abs_b;
  assign mn    = (abs_a > abs_b) ? abs_b : abs_a;
  assign mn_w  = (XW+2)'(mn);
  assign mag   = (XW+1)'(mx) + (XW+1)'((mn_w + (mn_w << 1)) >> 3);
  assign mag_f = (mag < FLOOR_V) ? FLOOR_V : mag;

  assign num  = NW'(q_i) <<< QS;
  assign quot = num / $signed({1'b0, mag_f});

  always_comb begin
    if (quot > NW'(EMAX))       err = TRIG_W'(EMAX);
    else if (quot < -NW'(EMAX)) err = -TRIG_W'(EMAX);
    else                        err = TRIG_W'(quot);
  end

  generate
    if (LAMBDA == 0) begin : g_fixed_gain
      assign ki_eff = 32'(KI);
    end else begin : g_adapt_gain
      logic [TRIG_W-1:0] abs_err;
      logic [47:0]       den;
      assign abs_err = TRIG_W'(err[TRIG_W-1] ? -err : err);
      assign den     = 48'(1 << QS) + 48'(LAMBDA) * 48'(abs_err);
      assign ki_eff  = 32'((48'(KI) << QS) / den);
    end
  endgenerate

  assign prop_w = 48'(err) * 48'(KP_S);
  assign inc_w  = 48'(err) * $signed({16'b0, ki_eff});
  assign acc_n  = acc_q + IW'(inc_w >>> QS);
  assign freq_n = ANG_W'(NOM_INC) + ANG_W'(acc_n >>> FRAC);
  assign freq_o = ANG_W'(NOM_INC) + ANG_W'(acc_q >>> FRAC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      angle_o <= '0;
    end else if (sample_i) begin
      acc_q   <= acc_n;
      angle_o <= angle_o + freq_n + ANG_W'(prop_w >>> QS);
    end
  end
endmodule

// File: rtl/srf_pll3.sv
module srf_pll3
  import srf_pll3_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ANG_W     = 16,
  parameter int RATED_HZ  = 60,
  parameter int SAMPLE_HZ = 7680,
  parameter int AO        = 16000,
  parameter int KP        = 179,
  parameter int KI        = 402,
  parameter int FRAC      = 8,
  parameter int LAMBDA    = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     sample_i,
  input  logic signed [DATA_W-1:0] va_i,
  input  logic signed [DATA_W-1:0] vb_i,
  input  logic signed [DATA_W-1:0] vc_i,
  output logic [ANG_W-1:0]         angle_o,
  output logic [ANG_W-1:0]         freq_o,
  output logic signed [DATA_W-1:0] d_o,
  output logic signed [DATA_W-1:0] q_o,
  output logic signed [DATA_W-1:0] z_o,
  output logic signed [15:0]       sin_o,
  output logic signed [15:0]       quad_o
);
  localparam int XW      = DATA_W + 2;
  localparam int NOM_INC = int'((longint'(RATED_HZ) << ANG_W) / longint'(SAMPLE_HZ));
  localparam int FLOOR   = (AO / 1000 > 0) ? AO / 1000 : 1;
  localparam logic signed [XW-1:0] HI = XW'((1 << (DATA_W - 1)) - 1);
  localparam logic signed [XW-1:0] LO = -HI;

  logic signed [TRIG_W-1:0] trig [3];
  logic signed [XW-1:0]     alpha, beta, d_w, q_w, z_w;

  // 0: sin, 1: cos, 2: sin a quarter turn back
  generate
    for (genvar g = 0; g < 3; g++) begin : g_trig
      localparam int OFF = (g == 0) ? 0 : ((g == 1) ? QTR : 3 * QTR);
      srf_pll3_sine #(.OFFSET(OFF)) u_sine (
        .idx_i (angle_o[ANG_W-1 -: LUT_BITS]),
        .val_o (trig[g])
      );
    end
  endgenerate

  srf_pll3_park #(.DATA_W(DATA_W), .XW(XW)) u_park (
    .va_i    (va_i),
    .vb_i    (vb_i),
    .vc_i    (vc_i),
    .sin_i   (trig[0]),
    .cos_i   (trig[1]),
    .alpha_o (alpha),
    .beta_o  (beta),
    .d_o     (d_w),
    .q_o     (q_w),
    .z_o     (z_w)
  );

  srf_pll3_loop #(
    .ANG_W(ANG_W), .XW(XW), .FRAC(FRAC), .KP(KP), .KI(KI),
    .LAMBDA(LAMBDA), .NOM_INC(NOM_INC), .FLOOR(FLOOR)
  ) u_loop (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sample_i (sample_i),
    .alpha_i  (alpha),
    .beta_i   (beta),
    .q_i      (q_w),
    .angle_o  (angle_o),
    .freq_o   (freq_o)
  );

  function automatic logic signed [DATA_W-1:0] sat(input logic signed [XW-1:0] x);
    if (x > HI) return DATA_W'(HI);
    if (x < LO) return DATA_W'(LO);
    return DATA_W'(x);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_o <= '0;
      q_o <= '0;
      z_o <= '0;
    end else if (sample_i) begin
      d_o <= sat(d_w);
      q_o <= sat(q_w);
      z_o <= sat(z_w);
    end
  end

  assign sin_o  = trig[0];
  assign quad_o = trig[2];
endmodule

// File: rtl/srf_pll3_chk.sv
module srf_pll3_chk #(
  parameter int DATA_W = 16,
  parameter int ANG_W  = 16
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     sample_i,
  input logic signed [DATA_W-1:0] va_i,
  input logic signed [DATA_W-1:0] vb_i,
  input logic signed [DATA_W-1:0] vc_i,
  input logic [ANG_W-1:0]         angle_o,
  input logic [ANG_W-1:0]         freq_o,
  input logic signed [DATA_W-1:0] d_o,
  input logic signed [DATA_W-1:0] q_o,
  input logic signed [DATA_W-1:0] z_o,
  input logic signed [15:0]       sin_o,
  input logic signed [15:0]       quad_o
);
  // R2
  hold_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_i |=> $stable(angle_o) && $stable(freq_o) && $stable(d_o) && $stable(q_o) && $stable(z_o));

  // R4
  common_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && va_i == vb_i && vb_i == vc_i |=> d_o == '0 && q_o == '0 && $stable(freq_o));

  // R8
  idle_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_i && va_i == '0 && vb_i == '0 && vc_i == '0
      |=> angle_o == ANG_W'($past(angle_o) + $past(freq_o)) && $stable(freq_o));

  // R10
  zero_angle_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    angle_o == '0 |-> sin_o == 16'sd0 && quad_o == -16'sd32767);

  // R10
  half_turn_trig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    angle_o == ANG_W'(1 << (ANG_W - 1)) |-> sin_o == 16'sd0 && quad_o == 16'sd32767);
endmodule

bind srf_pll3 srf_pll3_chk #(.DATA_W(DATA_W), .ANG_W(ANG_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sample_i (sample_i),
  .va_i     (va_i),
  .vb_i     (vb_i),
  .vc_i     (vc_i),
  .angle_o  (angle_o),
  .freq_o   (freq_o),
  .d_o      (d_o),
  .q_o      (q_o),
  .z_o      (z_o),
  .sin_o    (sin_o),
  .quad_o   (quad_o)
);

// File: tb/srf_pll3_test.sv
module srf_pll3_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp = 1'b0;
  logic signed [15:0] va = '0, vb = '0, vc = '0;
  logic [15:0] angle, freq, angle_l, freq_l;
  logic signed [15:0] d, q, z, s, qd, d_l, q_l, z_l, s_l, qd_l;
  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  srf_pll3 #(.KP(2048), .KI(8192), .LAMBDA(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .va_i(va), .vb_i(vb), .vc_i(vc),
    .angle_o(angle), .freq_o(freq), .d_o(d), .q_o(q), .z_o(z), .sin_o(s), .quad_o(qd));

  srf_pll3 #(.KP(2048), .KI(8192), .LAMBDA(10)) uut_lam (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(smp), .va_i(va), .vb_i(vb), .vc_i(vc),
    .angle_o(angle_l), .freq_o(freq_l), .d_o(d_l), .q_o(q_l), .z_o(z_l), .sin_o(s_l), .quad_o(qd_l));

  task automatic check_near(input string req, input string what, input int act, input int exp, input int tol);
    n_run++;
    if (act > exp + tol || act < exp - tol) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (tol %0d)", req, what, act, exp, tol);
    end
  endtask

  task automatic set_abc(input int a, input int b, input int c);
    va = 16'(a); vb = 16'(b); vc = 16'(c);
  endtask

  task automatic strobe();
    @(negedge clk) smp = 1'b1;
    @(negedge clk) smp = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    smp = 1'b0; set_abc(0, 0, 0); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    check_near("R1", "angle", int'(angle), 0, 0);
    check_near("R1", "freq", int'(freq), 512, 0);
    check_near("R1", "d/q/z", int'(d) + int'(q) + int'(z), 0, 0);
    check_near("R1", "sin", int'(s), 0, 0);
    check_near("R1", "quad", int'(qd), -32767, 0);
  endtask

  task automatic t_hold();
    do_reset();
    set_abc(10000, -5000, -5000);
    repeat (6) @(negedge clk);
    check_near("R2", "angle held", int'(angle), 0, 0);
    check_near("R2", "q held", int'(q), 0, 0);
    check_near("R2", "freq held", int'(freq), 512, 0);
  endtask

  task automatic t_idle_turn();
    do_reset();
    repeat (32) strobe();
    check_near("R8", "angle after 32", int'(angle), 16384, 0);
    check_near("R10", "sin at quarter", int'(s), 32767, 0);
    check_near("R10", "quad at quarter", int'(qd), 0, 0);
    repeat (32) strobe();
    check_near("R10", "sin at half", int'(s), 0, 0);
    check_near("R10", "quad at half", int'(qd), 32767, 0);
    repeat (63) strobe();
    check_near("R8", "angle after 127", int'(angle), 65024, 0);
    strobe();
    check_near("R8", "wrap after 128", int'(angle), 0, 0);
    check_near("R8", "freq idle", int'(freq), 512, 0);
  endtask

  task automatic t_locked();
    do_reset();
    set_abc(0, -8660, 8660);
    strobe();
    check_near("R3", "d locked", int'(d), 10000, 4);
    check_near("R3", "q locked", int'(q), 0, 4);
    check_near("R3", "angle locked", int'(angle), 512, 1);
    do_reset();
    repeat (32) strobe();
    set_abc(10000, -5000, -5000);
    strobe();
    check_near("R3", "d at 90deg", int'(d), 10000, 4);
    check_near("R3", "q at 90deg", int'(q), 0, 4);
    check_near("R3", "angle at 90deg", int'(angle), 16896, 1);
  endtask

  // both loop paths act on one edge: angle step = freq + KP, freq = NOM + KI/256
  task automatic t_lead();
    do_reset();
    set_abc(10000, -5000, -5000);
    strobe();
    check_near("R3", "q leading", int'(q), 10000, 4);
    check_near("R3", "d leading", int'(d), 0, 4);
    check_near("R7", "freq integral only", int'(freq), 544, 2);
    check_near("R8", "angle step", int'(angle), 2592, 4);
    check_near("R7", "angle minus freq", int'(angle) - int'(freq), 2048, 3);
    check_near("R5", "z leading", int'(z), 0, 1);
  endtask

  task automatic t_amplitude();
    do_reset();
    set_abc(2500, -1250, -1250);
    strobe();
    check_near("R5", "angle step at quarter amplitude", int'(angle), 2592, 4);
    check_near("R5", "freq at quarter amplitude", int'(freq), 544, 2);
  endtask

  task automatic t_floor();
    do_reset();
    set_abc(8, -4, -4);
    strobe();
    check_near("R6", "angle step below floor", int'(angle), 1552, 4);
    check_near("R6", "freq below floor", int'(freq), 528, 2);
  endtask

  task automatic t_common();
    do_reset();
    set_abc(3000, 3000, 3000);
    strobe();
    check_near("R4", "z mean", int'(z), 3000, 1);
    check_near("R4", "d zero", int'(d), 0, 0);
    check_near("R4", "q zero", int'(q), 0, 0);
    check_near("R4", "angle nominal", int'(angle), 512, 0);
    set_abc(-300, 900, 3000);
    strobe();
    check_near("R4", "z mean unequal", int'(z), 1200, 1);
  endtask

  task automatic t_lambda();
    do_reset();
    set_abc(10000, -5000, -5000);
    strobe();
    check_near("R9", "adaptive freq", int'(freq_l), 514, 2);
    check_near("R9", "adaptive angle", int'(angle_l), 2562, 4);
    check_near("R9", "fixed-gain freq", int'(freq), 544, 2);
  endtask

  initial begin
    t_reset();
    t_hold();
    t_idle_turn();
    t_locked();
    t_lead();
    t_amplitude();
    t_floor();
    t_common();
    t_lambda();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule